// File: doc/BRIEF.md
# SDRAM Burst Data Path

This block sequences the column accesses of a read or write burst for a 16-bit synchronous DRAM with two banks. A decoded command arrives together with a start column. The current mode word sets three things: the burst length (1, 2, 4, 8 words or a whole 256-column page), the address order (linear or interleaved) and the read latency (1, 2 or 3 cycles). From these the block drives one array access per cycle on its array-side port.

On a write, it forwards each input word with per-byte enables taken from the byte masks of the same cycle. On a read, it returns the fetched words on the read port after the programmed latency. Any output byte whose mask was high two cycles earlier is forced to zero. A stop command (precharge or burst terminate) cuts a burst short. A new read or write restarts the engine at once. The cell array sits outside the block and answers a read address in the same cycle.

Top module: `sdram_burst_path`

## Requirements
- R1: While reset is asserted and after its release with no command, `arr_we_o`, `arr_rd_o`, `rvalid_o` are low and `rdata_o` is zero.
- R2: The mode word is sampled only in the command cycle. Bits 2:0 select the length: 0→1, 1→2, 2→4, 3→8, 7→full page, and 4, 5, 6 give a single word. Bit 3 selects interleaved order when 1. Bits 6:4 select the latency: 1→1, 2→2, any other value→3.
- R3: The command encoding on `cmd_i` is 0 idle, 1 read, 2 write, 3 stop. For write beat k (the write command cycle is beat 0), the word and mask sampled at that beat's edge appear on the array port in the following cycle, with `arr_we_o` high. `arr_be_o[b]` is the inverse of `bmask_i[b]`, where bit 0 covers data bits 7:0 and bit 1 covers bits 15:8.
- R4: For a read command sampled at edge T, beat k is presented on `rdata_o` with `rvalid_o` high in the cycle sampled at edge T+latency+k.
- R5: In linear order with length L, beat k uses column (start − start mod L) + ((start mod L + k) mod L).
- R6: In interleaved order with length L of 8 or less, beat k uses column start XOR k.
- R7: A full-page burst visits (start + k) mod 256, ignores the order bit, and continues until a stop or a new command.
- R8: A mask bit high at edge t forces the matching byte of `rdata_o` to zero in the cycle sampled at edge t+2. `rdata_o` is zero whenever `rvalid_o` is low.
- R9: A stop command ends the burst. No array access occurs in the following cycle or later. Words already fetched before the stop are still delivered.
- R10: A read or write arriving during a burst abandons it. The next cycle carries beat 0 of the new burst at its start column.
- R11: `arr_we_o` and `arr_rd_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 2 | Decoded command: 0 idle, 1 read, 2 write, 3 stop |
| col_i | input | 8 | Start column, sampled with a read or write |
| mode_i | input | 7 | Mode word: length, order, latency |
| bmask_i | input | 2 | Byte masks, bit 1 upper byte, bit 0 lower byte |
| wdata_i | input | 16 | Write data for the current beat |
| rdata_o | output | 16 | Read data, masked bytes zero |
| rvalid_o | output | 1 | Read data valid |
| arr_addr_o | output | 8 | Array column address |
| arr_rd_o | output | 1 | Array read strobe |
| arr_we_o | output | 1 | Array write strobe |
| arr_wdata_o | output | 16 | Array write data |
| arr_be_o | output | 2 | Array byte write enables |
| arr_rdata_i | input | 16 | Array read data, same cycle as address |

## Verification
A corrupted beat counter or latched start column shows up on `arr_addr_o` in the very next cycle. The same wrong column surfaces again as a wrong word on `rdata_o` one to three cycles later. A wrong latency tap moves `rvalid_o` by at least one cycle against the reference timing. A misaligned mask history zeroes the wrong byte one cycle early or late. A burst-end flag that is wrong either leaves an extra array strobe one cycle after the last beat or drops one. The bench compares every array-side and read-side output in every cycle, so each of these faults is caught in the cycle it first appears.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;

    typedef enum logic [1:0] {
        BCMD_IDLE  = 2'd0,
        BCMD_READ  = 2'd1,
        BCMD_WRITE = 2'd2,
        BCMD_STOP  = 2'd3
    } bcmd_e;

    localparam int MODE_W = 7;
    localparam int MAX_LAT = 3;

    // latency field to cycles: 1 and 2 map directly, anything else is 3
    function automatic logic [1:0] lat_decode(input logic [2:0] code);
        case (code)
            3'd1:    return 2'd1;
            3'd2:    return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/sdram_col_gen.sv
module sdram_col_gen #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] start_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] lmask_i,
    input  logic             ilv_i,
    input  logic             full_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] offs;

    assign offs = start_i + beat_i;

    always_comb begin
        if (ilv_i && !full_i) begin
            col_o = start_i ^ (beat_i & lmask_i);
        end else begin
            // keep the aligned block bits, wrap the low bits
            col_o = (start_i & ~lmask_i) | (offs & lmask_i);
        end
    end
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
    import sdram_burst_pkg::*;
#(
    parameter int COL_W  = 8,
    parameter int DATA_W = 16,
    parameter int BYTES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bcmd_e             cmd_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [BYTES-1:0]  bmask_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [COL_W-1:0]  arr_addr_o,
    output logic              arr_rd_o,
    output logic              arr_we_o,
    output logic [DATA_W-1:0] arr_wdata_o,
    output logic [BYTES-1:0]  arr_be_o,
    output logic [1:0]        lat_o
);
    typedef struct packed {
        logic              act;
        logic              wr;
        logic              full;
        logic              ilv;
        logic [COL_W-1:0]  start;
        logic [COL_W-1:0]  beat;
        logic [COL_W-1:0]  lmask;
        logic [1:0]        lat;
        logic [COL_W-1:0]  addr;
        logic              rd;
        logic              we;
        logic [DATA_W-1:0] wdata;
        logic [BYTES-1:0]  be;
    } seq_t;

    seq_t s_d, s_q;
    logic [COL_W-1:0] col_nxt;
    logic [COL_W-1:0] cur_col;
    logic             issue;

    function automatic logic [COL_W-1:0] len_mask(input logic [2:0] code);
        case (code)
            3'd1:    return COL_W'(1);
            3'd2:    return COL_W'(3);
            3'd3:    return COL_W'(7);
            3'd7:    return '1;
            default: return '0;
        endcase
    endfunction

    sdram_col_gen #(.COL_W(COL_W)) u_col_gen (
        .start_i (s_q.start),
        .beat_i  (s_q.beat),
        .lmask_i (s_q.lmask),
        .ilv_i   (s_q.ilv),
        .full_i  (s_q.full),
        .col_o   (col_nxt)
    );

    always_comb begin
        s_d     = s_q;
        s_d.rd  = 1'b0;
        s_d.we  = 1'b0;
        issue   = 1'b0;
        cur_col = col_nxt;
        unique case (cmd_i)
            BCMD_STOP: begin
                s_d.act = 1'b0;
            end
            BCMD_READ, BCMD_WRITE: begin
                s_d.act   = 1'b1;
                s_d.wr    = (cmd_i == BCMD_WRITE);
                s_d.start = col_i;
                s_d.beat  = '0;
                s_d.lmask = len_mask(mode_i[2:0]);
                s_d.full  = (mode_i[2:0] == 3'd7);
                s_d.ilv   = mode_i[3];
                s_d.lat   = lat_decode(mode_i[6:4]);
                issue     = 1'b1;
                cur_col   = col_i;
            end
            default: begin
                issue = s_q.act;
            end
        endcase
        if (issue) begin
            s_d.addr = cur_col;
            s_d.rd   = !s_d.wr;
            s_d.we   = s_d.wr;
            if (s_d.wr) begin
                s_d.wdata = wdata_i;
                s_d.be    = ~bmask_i;
            end
            if (!s_d.full && (s_d.beat == s_d.lmask)) begin
                s_d.act = 1'b0;
            end
            s_d.beat = s_d.beat + COL_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign arr_addr_o  = s_q.addr;
    assign arr_rd_o    = s_q.rd;
    assign arr_we_o    = s_q.we;
    assign arr_wdata_o = s_q.wdata;
    assign arr_be_o    = s_q.be;
    assign lat_o       = s_q.lat;
endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe
    import sdram_burst_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_i,
    input  logic [DATA_W-1:0] rdata_i,
    input  logic [1:0]        lat_i,
    input  logic [BYTES-1:0]  bmask_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o
);
    localparam int STAGES = MAX_LAT - 1;

    typedef struct packed {
        logic [STAGES:1]             v;
        logic [STAGES:1][DATA_W-1:0] d;
        logic [BYTES-1:0]            m1;
        logic [BYTES-1:0]            m2;
    } pipe_t;

    pipe_t p_d, p_q;
    logic              sel_v;
    logic [DATA_W-1:0] sel_d;

    always_comb begin
        p_d      = p_q;
        p_d.v[1] = rd_i;
        p_d.d[1] = rdata_i;
        for (int i = 2; i <= STAGES; i++) begin
            p_d.v[i] = p_q.v[i-1];
            p_d.d[i] = p_q.d[i-1];
        end
        p_d.m1 = bmask_i;
        p_d.m2 = p_q.m1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    always_comb begin
        sel_v = rd_i;
        sel_d = rdata_i;
        for (int i = 1; i <= STAGES; i++) begin
            if (lat_i == 2'(i + 1)) begin
                sel_v = p_q.v[i];
                sel_d = p_q.d[i];
            end
        end
    end

    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        assign rdata_o[b*8 +: 8] = (sel_v && !p_q.m2[b]) ? sel_d[b*8 +: 8] : 8'h00;
    end

    assign rvalid_o = sel_v;
endmodule

// File: rtl/sdram_burst_path.sv
module sdram_burst_path
    import sdram_burst_pkg::*;
#(
    parameter int COL_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            cmd_i,
    input  logic [COL_W-1:0]      col_i,
    input  logic [6:0]            mode_i,
    input  logic [DATA_W/8-1:0]   bmask_i,
    input  logic [DATA_W-1:0]     wdata_i,
    output logic [DATA_W-1:0]     rdata_o,
    output logic                  rvalid_o,
    output logic [COL_W-1:0]      arr_addr_o,
    output logic                  arr_rd_o,
    output logic                  arr_we_o,
    output logic [DATA_W-1:0]     arr_wdata_o,
    output logic [DATA_W/8-1:0]   arr_be_o,
    input  logic [DATA_W-1:0]     arr_rdata_i
);
    localparam int BYTES = DATA_W / 8;

    logic [1:0] lat;

    sdram_burst_seq #(.COL_W(COL_W), .DATA_W(DATA_W), .BYTES(BYTES)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_i       (bcmd_e'(cmd_i)),
        .col_i       (col_i),
        .mode_i      (mode_i),
        .bmask_i     (bmask_i),
        .wdata_i     (wdata_i),
        .arr_addr_o  (arr_addr_o),
        .arr_rd_o    (arr_rd_o),
        .arr_we_o    (arr_we_o),
        .arr_wdata_o (arr_wdata_o),
        .arr_be_o    (arr_be_o),
        .lat_o       (lat)
    );

    sdram_rd_pipe #(.DATA_W(DATA_W), .BYTES(BYTES)) u_rd_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_i     (arr_rd_o),
        .rdata_i  (arr_rdata_i),
        .lat_i    (lat),
        .bmask_i  (bmask_i),
        .rdata_o  (rdata_o),
        .rvalid_o (rvalid_o)
    );
endmodule

// File: rtl/sdram_burst_path_chk.sv
module sdram_burst_path_chk #(
    parameter int COL_W  = 8,
    parameter int DATA_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          cmd_i,
    input logic [COL_W-1:0]    col_i,
    input logic [6:0]          mode_i,
    input logic [DATA_W/8-1:0] bmask_i,
    input logic [DATA_W-1:0]   wdata_i,
    input logic [DATA_W-1:0]   rdata_o,
    input logic                rvalid_o,
    input logic [COL_W-1:0]    arr_addr_o,
    input logic                arr_rd_o,
    input logic                arr_we_o,
    input logic [DATA_W-1:0]   arr_wdata_o,
    input logic [DATA_W/8-1:0] arr_be_o,
    input logic [DATA_W-1:0]   arr_rdata_i
);
    localparam int BYTES = DATA_W / 8;

    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= 2'd0;
        end else if (age_q != 2'd2) begin
            age_q <= age_q + 2'd1;
        end
    end

    // R11
    a_r11_single_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_we_o && arr_rd_o));

    // R9
    a_r9_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 2'd3) |=> (!arr_we_o && !arr_rd_o));

    // R3
    a_r3_write_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 2'd2) |=> (arr_we_o && arr_addr_o == $past(col_i)
                             && arr_wdata_o == $past(wdata_i)
                             && arr_be_o == ~$past(bmask_i)));

    // R10
    a_r10_read_start: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 2'd1) |=> (arr_rd_o && arr_addr_o == $past(col_i)));

    // R4
    a_r4_lat1_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 2'd1 && mode_i[6:4] == 3'd1) |=> rvalid_o);

    // R2
    a_r2_single_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 2'd1 && mode_i[2:0] == 3'd0) ##1 (cmd_i == 2'd0) |=> !arr_rd_o);

    // R8
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid_o |-> (rdata_o == '0));

    for (genvar b = 0; b < BYTES; b++) begin : g_mask
        // R8
        a_r8_read_mask: assert property (@(posedge clk) disable iff (!rst_n)
            (age_q == 2'd2 && rvalid_o && $past(bmask_i[b], 2)) |-> (rdata_o[b*8 +: 8] == 8'h00));
    end
endmodule

bind sdram_burst_path sdram_burst_path_chk #(.COL_W(COL_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sdram_burst_path_tb.sv
`timescale 1ns/1ps
module sdram_burst_path_tb;
    localparam int COL_W  = 8;
    localparam int DATA_W = 16;
    localparam int NCOL   = 256;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  cmd;
    logic [7:0]  col;
    logic [6:0]  mode;
    logic [1:0]  bmask;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic        rvalid;
    logic [7:0]  arr_addr;
    logic        arr_rd;
    logic        arr_we;
    logic [15:0] arr_wdata;
    logic [1:0]  arr_be;
    logic [15:0] arr_rdata;

    always #4 clk = ~clk;

    sdram_burst_path #(.COL_W(COL_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .col_i(col), .mode_i(mode),
        .bmask_i(bmask), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
        .arr_addr_o(arr_addr), .arr_rd_o(arr_rd), .arr_we_o(arr_we),
        .arr_wdata_o(arr_wdata), .arr_be_o(arr_be), .arr_rdata_i(arr_rdata)
    );

    // cell array model
    logic [15:0] mem [NCOL];
    assign arr_rdata = mem[arr_addr];
    always @(posedge clk) begin
        if (arr_we) begin
            if (arr_be[0]) mem[arr_addr][7:0]  <= arr_wdata[7:0];
            if (arr_be[1]) mem[arr_addr][15:8] <= arr_wdata[15:8];
        end
    end

    // reference model state
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;
    int          e = 0;
    bit          m_act = 0, m_wr = 0, m_full = 0, m_ilv = 0;
    int          m_start = 0, m_k = 0, m_len = 1, m_lat = 1;
    bit          ex_we = 0, ex_rd = 0;
    int          ex_addr = 0;
    logic [15:0] ex_wd = '0;
    logic [1:0]  ex_be = '0;
    logic [15:0] ref_mem [NCOL];
    logic [15:0] exp_rd [int];
    logic [1:0]  mask_hist [int];
    string       req = "R1";

    function automatic logic [6:0] md(int bl, int ilv, int lat);
        return {3'(lat), 1'(ilv), 3'(bl)};
    endfunction

    task automatic chk(string r, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at edge %0d", r, what, act, exp, e);
        end
    endtask

    task automatic compare();
        logic [15:0] d;
        logic [1:0]  mk;
        bit          v;
        chk(req, "arr_we", 32'(arr_we), 32'(ex_we));
        chk(req, "arr_rd", 32'(arr_rd), 32'(ex_rd));
        chk("R11", "exclusive strobes", 32'(arr_we && arr_rd), 32'd0);
        if (ex_we || ex_rd) chk(req, "arr_addr", 32'(arr_addr), 32'(ex_addr));
        if (ex_we) begin
            chk(req, "arr_wdata", 32'(arr_wdata), 32'(ex_wd));
            chk(req, "arr_be", 32'(arr_be), 32'(ex_be));
        end
        v = exp_rd.exists(e + 1);
        chk(req, "rvalid", 32'(rvalid), 32'(v));
        d = '0;
        if (v) begin
            d  = exp_rd[e + 1];
            mk = mask_hist.exists(e - 1) ? mask_hist[e - 1] : 2'b00;
            if (mk[0]) d[7:0]  = 8'h00;
            if (mk[1]) d[15:8] = 8'h00;
        end
        chk(req, "rdata", 32'(rdata), 32'(d));
    endtask

    task automatic model_edge(logic [1:0] c, int cc, logic [6:0] mw, logic [1:0] dq, logic [15:0] wd);
        bit issue;
        int a, base;
        e++;
        if (ex_we) begin
            if (ex_be[0]) ref_mem[ex_addr][7:0]  = ex_wd[7:0];
            if (ex_be[1]) ref_mem[ex_addr][15:8] = ex_wd[15:8];
        end
        mask_hist[e] = dq;
        issue = 0;
        ex_we = 0;
        ex_rd = 0;
        if (c == 2'd3) begin
            m_act = 0;
        end else if (c == 2'd1 || c == 2'd2) begin
            m_wr = (c == 2'd2);
            m_start = cc;
            m_k = 0;
            m_act = 1;
            case (mw[2:0])
                3'd0: m_len = 1;
                3'd1: m_len = 2;
                3'd2: m_len = 4;
                3'd3: m_len = 8;
                3'd7: m_len = 256;
                default: m_len = 1;
            endcase
            m_full = (mw[2:0] == 3'd7);
            m_ilv = mw[3];
            m_lat = (mw[6:4] == 3'd1) ? 1 : (mw[6:4] == 3'd2) ? 2 : 3;
            issue = 1;
        end else if (m_act) begin
            issue = 1;
        end
        if (issue) begin
            if (m_full) a = (m_start + m_k) % 256;
            else if (m_ilv) a = m_start ^ m_k;
            else begin
                base = m_start - (m_start % m_len);
                a = base + ((m_start % m_len) + m_k) % m_len;
            end
            ex_addr = a;
            if (m_wr) begin
                ex_we = 1;
                ex_wd = wd;
                ex_be = ~dq;
            end else begin
                ex_rd = 1;
                exp_rd[e + m_lat] = ref_mem[a];
            end
            m_k++;
            if (m_full) m_k = m_k % 256;
            else if (m_k == m_len) m_act = 0;
        end
    endtask

    task automatic tick(logic [1:0] c, int cc, logic [6:0] mw, logic [1:0] dq, logic [15:0] wd);
        compare();
        cmd = c; col = cc[7:0]; mode = mw; bmask = dq; wdata = wd;
        @(posedge clk);
        model_edge(c, cc, mw, dq, wd);
        @(negedge clk);
    endtask

    task automatic idle(int n, logic [6:0] mw);
        for (int i = 0; i < n; i++) tick(2'd0, 0, mw, 2'b00, 16'(e * 16'h0123 ^ 16'h5A5A));
    endtask

    initial begin
        for (int i = 0; i < NCOL; i++) begin
            mem[i]     = 16'(i * 16'h0101 ^ 16'hA5C3);
            ref_mem[i] = 16'(i * 16'h0101 ^ 16'hA5C3);
        end
        rst_n = 1'b0;
        cmd = 2'd0; col = '0; mode = '0; bmask = '0; wdata = '0;
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        chk("R1", "arr_we in reset", 32'(arr_we), 32'd0);
        chk("R1", "arr_rd in reset", 32'(arr_rd), 32'd0);
        chk("R1", "rvalid in reset", 32'(rvalid), 32'd0);
        chk("R1", "rdata in reset", 32'(rdata), 32'd0);
        rst_n = 1'b1;
        req = "R1";
        idle(3, md(0, 0, 1));

        // R3: linear length 4 write with per-beat masks
        req = "R3";
        tick(2'd2, 8, md(2, 0, 2), 2'b00, 16'h1111);
        tick(2'd0, 0, md(2, 0, 2), 2'b01, 16'h2222);
        tick(2'd0, 0, md(2, 0, 2), 2'b10, 16'h3333);
        tick(2'd0, 0, md(2, 0, 2), 2'b00, 16'h4444);
        idle(3, md(2, 0, 2));

        // R5: linear wrap inside aligned block
        req = "R5";
        tick(2'd1, 10, md(2, 0, 2), 2'b00, 16'h0);
        idle(6, md(2, 0, 2));
        tick(2'd1, 13, md(3, 0, 2), 2'b00, 16'h0);
        idle(10, md(3, 0, 2));

        // R4: latencies 1 and 3
        req = "R4";
        tick(2'd1, 8, md(1, 0, 1), 2'b00, 16'h0);
        idle(4, md(1, 0, 1));
        tick(2'd1, 9, md(1, 0, 3), 2'b00, 16'h0);
        idle(6, md(1, 0, 3));

        // R6: interleaved write then read
        req = "R6";
        tick(2'd2, 8'h25, md(3, 1, 3), 2'b00, 16'hC001);
        for (int i = 1; i < 8; i++) tick(2'd0, 0, md(3, 1, 3), 2'b00, 16'(16'hC001 + i));
        idle(2, md(3, 1, 3));
        tick(2'd1, 8'h23, md(3, 1, 3), 2'b00, 16'h0);
        idle(12, md(3, 1, 3));

        // R7: full page, order bit set but ignored
        req = "R7";
        tick(2'd1, 250, md(7, 1, 2), 2'b00, 16'h0);
        idle(270, md(7, 1, 2));
        tick(2'd3, 0, md(7, 1, 2), 2'b00, 16'h0);
        idle(5, md(7, 1, 2));

        // R8: read masks two cycles later
        req = "R8";
        tick(2'd1, 8'h40, md(3, 0, 2), 2'b01, 16'h0);
        for (int i = 0; i < 12; i++) tick(2'd0, 0, md(3, 0, 2), 2'(i % 4), 16'h0);
        idle(3, md(3, 0, 2));

        // R9: stop during write and during read
        req = "R9";
        tick(2'd2, 8'h60, md(3, 0, 3), 2'b00, 16'hD100);
        tick(2'd0, 0, md(3, 0, 3), 2'b00, 16'hD101);
        tick(2'd0, 0, md(3, 0, 3), 2'b00, 16'hD102);
        tick(2'd3, 0, md(3, 0, 3), 2'b00, 16'hD103);
        idle(3, md(3, 0, 3));
        tick(2'd1, 8'h60, md(3, 0, 3), 2'b00, 16'h0);
        idle(2, md(3, 0, 3));
        tick(2'd3, 0, md(3, 0, 3), 2'b00, 16'h0);
        idle(6, md(3, 0, 3));

        // R10: new command aborts a running burst
        req = "R10";
        tick(2'd2, 8'h80, md(3, 0, 2), 2'b00, 16'hE000);
        tick(2'd0, 0, md(3, 0, 2), 2'b00, 16'hE001);
        tick(2'd0, 0, md(3, 0, 2), 2'b00, 16'hE002);
        tick(2'd1, 8'h82, md(2, 0, 2), 2'b00, 16'h0);
        idle(6, md(2, 0, 2));
        tick(2'd1, 8'h90, md(3, 0, 2), 2'b00, 16'h0);
        tick(2'd0, 0, md(3, 0, 2), 2'b00, 16'h0);
        tick(2'd2, 8'h90, md(1, 0, 2), 2'b00, 16'hF0F0);
        tick(2'd0, 0, md(1, 0, 2), 2'b00, 16'hF1F1);
        idle(4, md(1, 0, 1));
        tick(2'd1, 8'h90, md(1, 0, 1), 2'b00, 16'h0);
        idle(4, md(1, 0, 1));

        // R2: reserved length codes and latency codes
        req = "R2";
        tick(2'd1, 8'h33, md(5, 0, 0), 2'b00, 16'h0);
        idle(6, md(5, 0, 0));
        tick(2'd2, 8'h34, md(6, 1, 7), 2'b11, 16'hABCD);
        idle(3, md(6, 1, 7));
        tick(2'd1, 8'h34, md(4, 0, 7), 2'b00, 16'h0);
        idle(6, md(4, 0, 7));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        done = 1;
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule